// File: doc/BRIEF.md
# Statistical Operation Sampling Controller

This block picks individual operations for profiling out of a stream of single-cycle issue pulses. A down-counter counts issued operations. When it runs out, the operation issuing in that cycle is marked as sampled, and the counter reloads from a programmable interval. When jitter is enabled, a pseudo-random value is folded into each reload, so that sampling does not lock onto the period of looping code. Selection is paced by the issue stream alone. No interrupt is involved.

Only one sampled operation may be in flight at a time. A sampled operation stays outstanding until a completion pulse returns. If the interval runs out while an operation is still outstanding, the new pick is dropped and a collision counter advances. This count is taken before any later record filtering. A population counter counts every issued operation, so that software can weight the results. The block also exposes a fixed minimum interval, which it uses whenever the programmed interval is zero. Record capture, filtering and storage happen downstream, started by the sample-start pulse.

Top module: `samp_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the busy flag, the start pulse, both counters and the jitter generator. It also loads the interval counter with the current base interval, so no operation is tagged for the first base-1 issued operations.
- R2: With jitter off and a base interval of N ≥ 1, every N-th issued operation reaches expiry. Cycles without an issue pulse do not advance the count. The expiring operation gets `sample_tag` high in its own issue cycle when the block is not busy.
- R3: A programmed interval of zero uses the value MIN_IVL as the base. `min_interval` always reads MIN_IVL.
- R4: `sample_start` is high for exactly the cycle after each cycle in which `sample_tag` is high.
- R5: `sample_busy` rises in the cycle after a tag. It stays high until a cycle with `op_done` high, and is low from the next cycle on. An `op_done` pulse while not busy has no effect.
- R6: An expiry while busy produces no tag and raises `collision_count` by one in the next cycle. This holds even when `op_done` arrives in the same cycle; the block is free again only from the cycle after the completion.
- R7: With jitter enabled, each reload value is the base XOR the low 8 bits of a 16-bit LFSR, with a result of zero replaced by 1. The LFSR starts at 0xACE1. On every expiry it shifts right and, when the bit shifted out is 1, is XORed with 0xB400. With jitter disabled, the base is loaded unchanged and the LFSR still advances.
- R8: `population_count` rises by one in the cycle after each issue pulse.
- R9: The base interval and the jitter enable are sampled only at a reload or at reset. A change takes effect from the next reload.
- R10: Both counters wrap to zero past their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_issue | input | 1 | One operation issues this cycle |
| op_done | input | 1 | The outstanding sampled operation completes |
| cfg_interval | input | IW | Programmed sampling interval, zero selects the minimum |
| cfg_jitter_en | input | 1 | Fold LFSR bits into each reload |
| min_interval | output | IW | Fixed minimum interval |
| sample_tag | output | 1 | The operation issuing now is sampled |
| sample_start | output | 1 | Capture start, one cycle after a tag |
| sample_busy | output | 1 | A sampled operation is outstanding |
| collision_count | output | CW | Dropped picks, counted before filtering |
| population_count | output | CW | Issued operations |

## Verification
A reference model tracks every issue, completion and reload, and the outputs are compared with it on every cycle. A wrong interval count or a wrong reload shows at the next expiry: a tag appears in the wrong cycle, or a collision is counted in the wrong cycle. A mistake in the LFSR shows only when jitter is on, and only as a shifted tag position one interval later. A stuck or early-cleared busy flag shows at once on `sample_busy`, and at the next expiry as a wrong tag or collision.

// File: rtl/samp_pkg.sv
package samp_pkg;
   localparam int LFSR_W = 16;
   localparam int JIT_W  = 8;
   localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

   function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
      return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
   endfunction
endpackage

// File: rtl/samp_jitter.sv
module samp_jitter
   import samp_pkg::*;
#(
   parameter bit                HAS_JIT = 1'b1,
   parameter logic [LFSR_W-1:0] SEED    = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             en,
   output logic [JIT_W-1:0] jit
);
   generate
      if (SEED == '0) begin : g_bad_seed
         $error("samp_jitter: SEED must be nonzero");
      end
      if (HAS_JIT) begin : g_lfsr
         logic [LFSR_W-1:0] st;
         always_ff @(posedge clk) begin
            if (rst)      st <= SEED;
            else if (adv) st <= lfsr_next(st);
         end
         assign jit = en ? st[JIT_W-1:0] : '0;

         // R7: a maximal-length register never reaches the all-zero state
         assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst)
            st != '0);
         // R7: the state only moves on an expiry
         assert_lfsr_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !adv |=> $stable(st));
      end else begin : g_none
         assign jit = '0;
      end
   endgenerate
endmodule

// File: rtl/samp_interval.sv
module samp_interval
   import samp_pkg::*;
#(
   parameter int IW      = 16,
   parameter int MIN_IVL = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             issue,
   input  logic [IW-1:0]    cfg_ivl,
   input  logic [JIT_W-1:0] jit,
   output logic             expire
);
   localparam logic [IW-1:0] MIN_V = IW'(MIN_IVL);
   localparam logic [IW-1:0] ONE   = IW'(1);

   generate
      if (IW <= JIT_W) begin : g_bad_width
         $error("samp_interval: IW must exceed the jitter width");
      end
      if (MIN_IVL < 1 || MIN_IVL >= (1 << IW)) begin : g_bad_min
         $error("samp_interval: MIN_IVL out of range");
      end
   endgenerate

   logic [IW-1:0] cnt;
   logic [IW-1:0] base;
   logic [IW-1:0] mixed;
   logic [IW-1:0] reload;

   always_comb begin
      base   = (cfg_ivl == '0) ? MIN_V : cfg_ivl;
      mixed  = base ^ {{(IW-JIT_W){1'b0}}, jit};
      reload = (mixed == '0) ? ONE : mixed;
   end

   assign expire = issue && (cnt == ONE);

   always_ff @(posedge clk) begin
      if (rst)         cnt <= base;
      else if (expire) cnt <= reload;
      else if (issue)  cnt <= cnt - ONE;
   end

   // R2: the count never sits at zero
   assert_cnt_live_R2: assert property (@(posedge clk) disable iff (rst)
      cnt != '0);
   // R2: idle cycles leave the count alone
   assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !issue |=> $stable(cnt));
endmodule

// File: rtl/samp_inflight.sv
module samp_inflight (
   input  logic clk,
   input  logic rst,
   input  logic expire,
   input  logic op_done,
   output logic tag,
   output logic busy,
   output logic collide,
   output logic start
);
   logic busy_q;
   logic start_q;

   assign tag     = expire && !busy_q;
   assign collide = expire && busy_q;
   assign busy    = busy_q;
   assign start   = start_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= tag;
         if (tag)          busy_q <= 1'b1;
         else if (op_done) busy_q <= 1'b0;
      end
   end

   assert_start_follows_R4: assert property (@(posedge clk) disable iff (rst)
      tag |=> start);
   assert_busy_hold_R5: assert property (@(posedge clk) disable iff (rst)
      busy && !op_done |=> busy);
   assert_busy_release_R5: assert property (@(posedge clk) disable iff (rst)
      busy && op_done |=> !busy);
   assert_no_tag_busy_R6: assert property (@(posedge clk) disable iff (rst)
      busy |-> !tag);
endmodule

// File: rtl/samp_evcnt.sv
module samp_evcnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   output logic [CW-1:0] count
);
   generate
      if (CW < 1) begin : g_bad_cw
         $error("samp_evcnt: CW must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      count <= '0;
      else if (inc) count <= count + CW'(1);
   end

   // R8 and R6: one step per event, wrapping per R10
   assert_step_R10: assert property (@(posedge clk) disable iff (rst)
      inc |=> count == $past(count) + CW'(1));
   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(count));
endmodule

// File: rtl/samp_ctrl.sv
module samp_ctrl
   import samp_pkg::*;
#(
   parameter int                IW      = 16,
   parameter int                CW      = 16,
   parameter int                MIN_IVL = 64,
   parameter bit                HAS_JIT = 1'b1,
   parameter logic [LFSR_W-1:0] SEED    = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          op_issue,
   input  logic          op_done,
   input  logic [IW-1:0] cfg_interval,
   input  logic          cfg_jitter_en,
   output logic [IW-1:0] min_interval,
   output logic          sample_tag,
   output logic          sample_start,
   output logic          sample_busy,
   output logic [CW-1:0] collision_count,
   output logic [CW-1:0] population_count
);
   logic             expire;
   logic             collide;
   logic [JIT_W-1:0] jit;

   assign min_interval = IW'(MIN_IVL);

   samp_jitter #(.HAS_JIT(HAS_JIT), .SEED(SEED)) u_jit (
      .clk(clk), .rst(rst), .adv(expire), .en(cfg_jitter_en), .jit(jit)
   );

   samp_interval #(.IW(IW), .MIN_IVL(MIN_IVL)) u_ivl (
      .clk(clk), .rst(rst), .issue(op_issue), .cfg_ivl(cfg_interval),
      .jit(jit), .expire(expire)
   );

   samp_inflight u_fly (
      .clk(clk), .rst(rst), .expire(expire), .op_done(op_done),
      .tag(sample_tag), .busy(sample_busy), .collide(collide),
      .start(sample_start)
   );

   samp_evcnt #(.CW(CW)) u_coll (
      .clk(clk), .rst(rst), .inc(collide), .count(collision_count)
   );

   samp_evcnt #(.CW(CW)) u_pop (
      .clk(clk), .rst(rst), .inc(op_issue), .count(population_count)
   );

   // R6: an expiry met by a busy flag lands in the collision count
   assert_collision_counted_R6: assert property (@(posedge clk) disable iff (rst)
      expire && sample_busy |=> collision_count == $past(collision_count) + CW'(1));
   // R2: a tag only ever accompanies an issued operation
   assert_tag_on_issue_R2: assert property (@(posedge clk) disable iff (rst)
      sample_tag |-> op_issue);
   // R8: every issue advances the population
   assert_pop_counted_R8: assert property (@(posedge clk) disable iff (rst)
      op_issue |=> population_count == $past(population_count) + CW'(1));
endmodule

// File: tb/test_samp_ctrl.sv
`timescale 1ns/1ps
module test_samp_ctrl;
   localparam int IW = 16;
   localparam int CW = 16;
   localparam int MINV = 64;
   localparam int WRAP = 1 << CW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          op_issue = 1'b0;
   logic          op_done = 1'b0;
   logic [IW-1:0] cfg_interval = IW'(4);
   logic          cfg_jitter_en = 1'b0;
   logic [IW-1:0] min_interval;
   logic          sample_tag, sample_start, sample_busy;
   logic [CW-1:0] collision_count, population_count;

   samp_ctrl #(.IW(IW), .CW(CW), .MIN_IVL(MINV)) i_samp_ctrl (
      .clk(clk), .rst(rst), .op_issue(op_issue), .op_done(op_done),
      .cfg_interval(cfg_interval), .cfg_jitter_en(cfg_jitter_en),
      .min_interval(min_interval), .sample_tag(sample_tag),
      .sample_start(sample_start), .sample_busy(sample_busy),
      .collision_count(collision_count), .population_count(population_count)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int nxt_ivl = 4;
   bit nxt_jen = 0;

   int m_cnt, m_lfsr, m_coll, m_pop;
   bit m_busy, m_start, m_valid = 0, m_fresh = 0;

   function automatic int base_of(int v);
      return (v == 0) ? MINV : v;
   endfunction

   function automatic int lfsr_step(int s);
      return (s & 1) ? ((s >> 1) ^ 'hB400) : (s >> 1);
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(bit r, bit iss, bit dn);
      bit expire, tag;
      int j, rv;
      string pre;
      @(negedge clk);
      rst = r; op_issue = iss; op_done = dn;
      cfg_interval = IW'(nxt_ivl); cfg_jitter_en = nxt_jen;
      #1;
      if (m_valid && !r) begin
         pre = m_fresh ? "R1 " : "";
         tag = iss && (m_cnt == 1) && !m_busy;
         chk({pre, "R2 R3 R7 R9 sample_tag"}, int'(sample_tag), int'(tag));
         chk({pre, "R5 sample_busy"}, int'(sample_busy), int'(m_busy));
         chk({pre, "R4 sample_start"}, int'(sample_start), int'(m_start));
         chk({pre, "R6 collision_count"}, int'(collision_count), m_coll);
         chk({pre, "R8 R10 population_count"}, int'(population_count), m_pop);
         m_fresh = 0;
      end
      if (r) begin
         m_cnt = base_of(nxt_ivl); m_busy = 0; m_start = 0;
         m_coll = 0; m_pop = 0; m_lfsr = 'hACE1; m_valid = 1; m_fresh = 1;
      end else begin
         expire = iss && (m_cnt == 1);
         tag = expire && !m_busy;
         m_start = tag;
         if (expire) begin
            if (m_busy) m_coll = (m_coll + 1) % WRAP;
            j = nxt_jen ? (m_lfsr & 255) : 0;
            rv = base_of(nxt_ivl) ^ j;
            if (rv == 0) rv = 1;
            m_cnt = rv;
            m_lfsr = lfsr_step(m_lfsr);
         end else if (iss) begin
            m_cnt--;
         end
         if (tag) m_busy = 1;
         else if (dn) m_busy = 0;
         if (iss) m_pop = (m_pop + 1) % WRAP;
      end
   endtask

   function automatic bit roll(int pct);
      return $urandom_range(99) < pct;
   endfunction

   task automatic run(int n, int p_iss, int p_done);
      for (int k = 0; k < n; k++) step(0, roll(p_iss), roll(p_done));
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL R1 watchdog actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state, interval 4
      for (int k = 0; k < 3; k++) step(1, 0, 0);
      chk("R3 min_interval", int'(min_interval), MINV);
      // R2: every fourth issue, quick completions
      run(300, 100, 60);
      // R2: sparse issue pattern, idle cycles must not count
      run(300, 40, 60);
      // R6: completions rare, collisions pile up
      run(400, 100, 3);
      // R5: stray completions while idle, interval 1
      nxt_ivl = 1;
      run(200, 80, 50);
      // R3: zero interval uses the minimum
      nxt_ivl = 0;
      run(600, 100, 20);
      // R7: jitter on, R9: interval changed mid-run
      nxt_ivl = 20; nxt_jen = 1;
      run(2000, 70, 20);
      nxt_ivl = 7;
      run(2000, 90, 10);
      // R7: jitter reload equal to base, zero replaced by one
      nxt_ivl = 'hE1;
      run(1500, 100, 30);
      nxt_jen = 0; nxt_ivl = 5;
      run(300, 100, 30);
      // R1: reset in mid-run
      step(1, 1, 1);
      step(1, 0, 0);
      // R10: wrap the population counter
      nxt_ivl = 3;
      run(66000, 100, 30);
      finished = 1;
      summary();
      $finish;
   end
endmodule